// File: doc/BRIEF.md
# SAR ADC SPI Reader

This block is an SPI master that fetches a single conversion from a successive-approximation ADC. The converter family it serves comes in variants with 1, 2, 4 or 8 analog inputs and a resolution of 10, 12 or 13 bits. The variant is fixed at compile time through parameters. A host presents a channel index and a differential flag, then pulses a start input. The block runs one SPI frame in mode 0, MSB first. Multi-input variants receive an 8-bit command before the data bytes. Single-input variants are receive-only.

When the frame ends, the block turns the last two received bytes into a result according to the variant. The result is right-aligned and zero-extended, except on the 13-bit variant, where it is sign-extended to 16 bits. A one-cycle done strobe marks the new result. A request the variant cannot serve gets no result and runs no frame: the block raises an error flag together with done instead.

The SCLK half-period is `CLK_DIV` system clocks. A host that wants a differential reading names the first channel of the pair. The polarity of the pair follows from that choice.

Top module: `sar_spi_reader`

## Requirements
- R1: During and after a synchronous active-low reset: `cs_n_o` = 1, `sclk_o` = 0, `mosi_o` = 0, `done_o` = 0, `error_o` = 0 and `result_o` = 0.
- R2: A frame uses SPI mode 0, MSB first.
  - SCLK is low when chip select falls and toggles only while chip select is low.
  - MOSI changes only while SCLK is low.
  - MISO is sampled on each rising SCLK edge.
- R3: On 2-input variants, the command byte has these fields:
  - bit 4 = 1 (start marker);
  - bit 3 = NOT differential;
  - bit 2 = channel;
  - all other bits 0.
- R4: On 4- and 8-input variants, the command byte has these fields:
  - bit 6 = 1 (start marker);
  - bit 5 = NOT differential;
  - bits 4:2 = channel;
  - all other bits 0.
- R5: Single-input variants send no command and hold `mosi_o` at 0 for the whole frame.
- R6: A frame has exactly 8 × ceil(RES_BITS/8) SCLK periods, plus 8 more when the variant has more than one input.
- R7: With b0 and b1 the last two received bytes (b0 first), multi-input variants return:
  - at 10 bits: (b0<<2)|(b1>>6);
  - at 12 bits: (b0<<4)|(b1>>4).
- R8: Single-input variants return:
  - at 10 bits: the low 10 bits of (b0<<5)|(b1>>3);
  - at 12 bits: the low 12 bits of (b0<<7)|(b1>>1).
- R9: The 13-bit single-input variant takes ((b0 & 0x1F)<<8)|b1 and sign-extends it from bit 12 to a 16-bit two's-complement result.
- R10: A differential request sends the channel index unchanged, so the index names the non-inverting member of the pair. For example, 3 selects (3,2) and 2 selects (2,3).
- R11: A request is rejected when the channel index is not below the input count, or when the variant itself is unsupported. Supported variants have 1, 2, 4 or 8 inputs and 10 or 12 bits, or 1 input and 13 bits. On a rejected request:
  - `done_o` and `error_o` are high together one cycle after start;
  - no frame runs;
  - `result_o` keeps its value.
- R12: A start pulse is ignored from the cycle it is accepted until the cycle in which chip select returns high, that cycle included.
- R13: Chip select returns high 2×CLK_DIV cycles after the last falling SCLK edge. `done_o` is high for exactly the following cycle, with the new result and `error_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse |
| chan_i | input | 3 | Channel index (first member of the pair if differential) |
| diff_i | input | 1 | 1 = differential, 0 = single-ended |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the converter |
| done_o | output | 1 | One-cycle completion strobe |
| error_o | output | 1 | Request rejected (valid with done_o) |
| result_o | output | 16 | Conversion result |

## Verification
The assertions watch the framing rules on every cycle:
- SCLK only under chip select, and SCLK low at the chip-select fall;
- done for a single cycle, one cycle after chip select rises;
- an error only with done and never beside a frame;
- the result steady except at a good completion;
- MOSI silent on single-input variants;
- no strobe caused by a start that arrives mid-frame.

Only the bench scenarios can show the rest, because that depends on bit values and counts:
- the command byte contents for each input count and for both pair orders;
- the number of SCLK periods;
- the extraction and sign extension for each resolution;
- the exact cycle count from start to done.

// File: rtl/sar_rd_pkg.sv
// Shared constants, state type and variant helpers for the SAR ADC reader.
// Assumes the variant parameters are elaboration-time constants.
package sar_rd_pkg;

    localparam int RESULT_W = 16;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_TAIL  = 2'd2
    } eng_state_e;

    // True when the input count / resolution pair is one the reader can serve.
    function automatic bit variant_ok(int n_inputs, int res_bits);
        bit count_ok;
        count_ok = (n_inputs == 1) || (n_inputs == 2) || (n_inputs == 4) || (n_inputs == 8);
        if (!count_ok) return 1'b0;
        if (res_bits == 10 || res_bits == 12) return 1'b1;
        return (res_bits == 13) && (n_inputs == 1);
    endfunction

    // Receive field length in bits: whole bytes, never below two bytes.
    function automatic int rx_field_bits(int res_bits);
        return (res_bits > 8) ? 8 * ((res_bits + 7) / 8) : 16;
    endfunction

endpackage

// File: rtl/sar_cmd_build.sv
// Builds the command byte for the configured input count and flags whether
// the requested channel exists. Purely combinational; single-input variants
// produce an all-zero byte that the top never transmits.
module sar_cmd_build #(
    parameter int N_INPUTS = 8
) (
    input  logic [2:0] chan_i,
    input  logic       diff_i,
    output logic [7:0] cmd_o,
    output logic       chan_ok_o
);

    // Channel range check against the input count
    assign chan_ok_o = (int'(chan_i) < N_INPUTS);

    generate
        if (N_INPUTS == 2) begin : g_two
            // start marker at bit 4, single-ended flag at bit 3, channel at bit 2
            assign cmd_o = {3'b000, 1'b1, ~diff_i, chan_i[0], 2'b00};
        end else if (N_INPUTS > 2) begin : g_many
            // start marker at bit 6, single-ended flag at bit 5, channel at bits 4:2
            assign cmd_o = {1'b0, 1'b1, ~diff_i, chan_i, 2'b00};
        end else begin : g_none
            // receive-only variant: no command
            assign cmd_o = 8'h00;
        end
    endgenerate

endmodule

// File: rtl/sar_spi_engine.sv
// Mode-0 SPI frame sequencer. On go it lowers chip select, shifts N_BITS
// bits out MSB first (MOSI changes while SCLK is low) and samples MISO on
// every rising SCLK edge. It holds chip select one more SCLK period after
// the last falling edge, then raises it and pulses fin. Assumes go only
// arrives while busy_o is low.
module sar_spi_engine
    import sar_rd_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int N_BITS  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [N_BITS-1:0] tx_i,
    input  logic              miso_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              fin_o,
    output logic [15:0]       rx_o
);

    localparam int CNT_W = ($clog2(2 * CLK_DIV) < 1) ? 1 : $clog2(2 * CLK_DIV);
    localparam int BIT_W = $clog2(N_BITS + 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(2 * CLK_DIV - 1);

    eng_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  left_q;
    logic [N_BITS-1:0] tx_q;
    logic [15:0]       rx_q;
    logic              cs_q;
    logic              sclk_q;
    logic              fin_q;

    assign cs_n_o = cs_q;
    assign sclk_o = sclk_q;
    assign mosi_o = tx_q[N_BITS-1] & ~cs_q;
    assign busy_o = (st_q != ENG_IDLE) | fin_q;
    assign fin_o  = fin_q;
    assign rx_o   = rx_q;

    // Frame sequencing: divider, bit counter, shift registers and select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENG_IDLE;
            cnt_q  <= '0;
            left_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (st_q)
                ENG_IDLE: begin
                    if (go_i) begin
                        st_q   <= ENG_SHIFT;
                        cs_q   <= 1'b0;
                        cnt_q  <= '0;
                        left_q <= BIT_W'(N_BITS);
                        tx_q   <= tx_i;
                    end
                end
                ENG_SHIFT: begin
                    if (cnt_q == HALF_LAST) begin
                        cnt_q <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            rx_q   <= {rx_q[14:0], miso_i};
                        end else begin
                            sclk_q <= 1'b0;
                            tx_q   <= tx_q << 1;
                            left_q <= left_q - BIT_W'(1);
                            if (left_q == BIT_W'(1)) begin
                                st_q <= ENG_TAIL;
                            end
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ENG_TAIL: begin
                    if (cnt_q == TAIL_LAST) begin
                        cnt_q <= '0;
                        cs_q  <= 1'b1;
                        fin_q <= 1'b1;
                        st_q  <= ENG_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_result_extract.sv
// Maps the last two received bytes to the 16-bit result for the variant:
// right-aligned and zero-extended, or sign-extended for the 13-bit part.
// Purely combinational.
module sar_result_extract
    import sar_rd_pkg::*;
#(
    parameter int N_INPUTS = 8,
    parameter int RES_BITS = 12
) (
    input  logic [7:0]          b0_i,
    input  logic [7:0]          b1_i,
    output logic [RESULT_W-1:0] value_o
);

    logic [15:0] pair;
    assign pair = {b0_i, b1_i};

    generate
        if (N_INPUTS > 1 && RES_BITS == 10) begin : g_m10
            assign value_o = RESULT_W'(pair >> 6);
        end else if (N_INPUTS > 1) begin : g_m12
            assign value_o = RESULT_W'(pair >> 4);
        end else if (RES_BITS == 13) begin : g_s13
            logic [12:0] raw;
            assign raw     = 13'(pair & 16'h1FFF);
            assign value_o = {{(RESULT_W - 13){raw[12]}}, raw};
        end else if (RES_BITS == 10) begin : g_s10
            assign value_o = RESULT_W'((pair >> 3) & 16'h03FF);
        end else begin : g_s12
            assign value_o = RESULT_W'((pair >> 1) & 16'h0FFF);
        end
    endgenerate

endmodule

// File: rtl/sar_spi_reader.sv
// Top of the SAR ADC reader. It accepts a start request while the frame
// engine is idle, checks the request against the compiled variant, and
// either rejects it with an error strobe or runs one SPI frame. After the
// frame it registers the extracted result and pulses done. Starts that
// arrive while a frame is in flight are dropped.
module sar_spi_reader
    import sar_rd_pkg::*;
#(
    parameter int N_INPUTS = 8,
    parameter int RES_BITS = 12,
    parameter int CLK_DIV  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2:0]          chan_i,
    input  logic                diff_i,
    input  logic                miso_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic                done_o,
    output logic                error_o,
    output logic [RESULT_W-1:0] result_o
);

    localparam bit VARIANT_OK = variant_ok(N_INPUTS, RES_BITS);
    localparam int CMD_BITS   = (N_INPUTS > 1) ? 8 : 0;
    localparam int RX_BITS    = rx_field_bits(RES_BITS);
    localparam int N_BITS     = CMD_BITS + RX_BITS;

    logic [7:0]          cmd;
    logic                chan_ok;
    logic [N_BITS-1:0]   tx_word;
    logic                eng_busy;
    logic                eng_fin;
    logic [15:0]         eng_rx;
    logic [RESULT_W-1:0] ext_val;
    logic                accept;
    logic                go;
    logic                reject;
    logic                done_q;
    logic                err_q;
    logic [RESULT_W-1:0] res_q;

    sar_cmd_build #(.N_INPUTS(N_INPUTS)) u_cmd (
        .chan_i    (chan_i),
        .diff_i    (diff_i),
        .cmd_o     (cmd),
        .chan_ok_o (chan_ok)
    );

    generate
        if (CMD_BITS > 0) begin : g_tx_cmd
            assign tx_word = {cmd, RX_BITS'(0)};
        end else begin : g_tx_none
            logic unused_cmd;
            assign unused_cmd = ^cmd;
            assign tx_word    = '0;
        end
    endgenerate

    // Request qualification
    assign accept = start_i & ~eng_busy;
    assign go     = accept & VARIANT_OK & chan_ok;
    assign reject = accept & ~(VARIANT_OK & chan_ok);

    sar_spi_engine #(.CLK_DIV(CLK_DIV), .N_BITS(N_BITS)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .tx_i   (tx_word),
        .miso_i (miso_i),
        .cs_n_o (cs_n_o),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .busy_o (eng_busy),
        .fin_o  (eng_fin),
        .rx_o   (eng_rx)
    );

    sar_result_extract #(.N_INPUTS(N_INPUTS), .RES_BITS(RES_BITS)) u_ext (
        .b0_i    (eng_rx[15:8]),
        .b1_i    (eng_rx[7:0]),
        .value_o (ext_val)
    );

    // Completion strobe, error flag and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= eng_fin | reject;
            err_q  <= reject;
            if (eng_fin) begin
                res_q <= ext_val;
            end
        end
    end

    assign done_o   = done_q;
    assign error_o  = err_q;
    assign result_o = res_q;

endmodule

// File: rtl/sar_spi_reader_chk.sv
// Cycle-level protocol checks for sar_spi_reader, bound to every instance.
module sar_spi_reader_chk #(
    parameter int N_INPUTS = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        cs_n_o,
    input logic        sclk_o,
    input logic        mosi_o,
    input logic        done_o,
    input logic        error_o,
    input logic [15:0] result_o
);

    AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o); // R2
    AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !sclk_o); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R13
    AST_DONE_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> (done_o && !error_o)); // R13
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o); // R11
    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (cs_n_o && $past(cs_n_o))); // R11
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && !error_o) |-> $stable(result_o)); // R11
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !cs_n_o) |=> !done_o); // R12

    generate
        if (N_INPUTS == 1) begin : g_single
            AST_NO_MOSI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                !mosi_o); // R5
        end
    endgenerate

endmodule

bind sar_spi_reader sar_spi_reader_chk #(.N_INPUTS(N_INPUTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .done_o   (done_o),
    .error_o  (error_o),
    .result_o (result_o)
);

// File: tb/sim_sar_spi_reader.sv
// Converter model: loads a 24-bit reply stream when chip select falls,
// presents its MSB on MISO, shifts after each falling SCLK, captures the
// first 8 MOSI bits on rising SCLK, and counts SCLK periods and frames.
module sim_adc_model (
    input  logic        clk,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        mosi,
    input  logic [23:0] stream,
    output logic        miso,
    output logic [7:0]  cmd_seen,
    output int          edges,
    output int          frames
);
    logic [23:0] sr;
    logic        cs_prev;
    logic        sclk_prev;

    initial begin
        sr = '0; cmd_seen = '0; edges = 0; frames = 0; cs_prev = 1'b1; sclk_prev = 1'b0;
    end

    assign miso = sr[23];

    always @(negedge clk) begin
        cs_prev   <= cs_n;
        sclk_prev <= sclk;
        if (cs_prev && !cs_n) begin
            sr       <= stream;
            edges    <= 0;
            frames   <= frames + 1;
            cmd_seen <= '0;
        end else if (!cs_n) begin
            if (!sclk_prev && sclk) begin
                if (edges < 8) cmd_seen <= {cmd_seen[6:0], mosi};
                edges <= edges + 1;
            end
            if (sclk_prev && !sclk) sr <= sr << 1;
        end
    end
endmodule

module sim_sar_spi_reader;

    localparam int NV = 7;
    localparam int NI [NV] = '{8, 1, 2, 1, 4, 2, 1};
    localparam int RB [NV] = '{12, 13, 10, 10, 12, 13, 12};
    localparam int DIV = 2;

    typedef struct {
        logic        err;
        logic [15:0] res;
        logic [7:0]  cmd;
        int          bits;
        int          frames;
        string       tag;
        string       cmd_tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start [NV];
    logic        diff [NV];
    logic [2:0]  chan [NV];
    logic [23:0] stream [NV];
    logic        cs_n [NV];
    logic        sclk [NV];
    logic        mosi [NV];
    logic        miso [NV];
    logic        done [NV];
    logic        err [NV];
    logic [15:0] res [NV];
    logic [7:0]  cmd_seen [NV];
    int          edges [NV];
    int          frames [NV];

    item_t       exp_q [NV][$];
    logic [15:0] last_res [NV];
    int          frames_exp [NV];
    int          checks = 0;
    int          errors = 0;

    for (genvar g = 0; g < NV; g++) begin : g_dut
        sar_spi_reader #(.N_INPUTS(NI[g]), .RES_BITS(RB[g]), .CLK_DIV(DIV)) u0 (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start[g]),
            .chan_i   (chan[g]),
            .diff_i   (diff[g]),
            .miso_i   (miso[g]),
            .cs_n_o   (cs_n[g]),
            .sclk_o   (sclk[g]),
            .mosi_o   (mosi[g]),
            .done_o   (done[g]),
            .error_o  (err[g]),
            .result_o (res[g])
        );
        sim_adc_model u_adc (
            .clk      (clk),
            .cs_n     (cs_n[g]),
            .sclk     (sclk[g]),
            .mosi     (mosi[g]),
            .stream   (stream[g]),
            .miso     (miso[g]),
            .cmd_seen (cmd_seen[g]),
            .edges    (edges[g]),
            .frames   (frames[g])
        );
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Expected command byte from the stated layouts (R3, R4, R5)
    function automatic logic [7:0] exp_cmd(int ni, int ch, bit df);
        if (ni == 1) return 8'h00;
        if (ni == 2) return 8'(16 + (df ? 0 : 8) + ch * 4);
        return 8'(64 + (df ? 0 : 32) + ch * 4);
    endfunction

    // Expected result from the stated extraction rules (R7, R8, R9)
    function automatic logic [15:0] exp_res(int ni, int rb, int r0, int r1);
        int v;
        if (ni > 1) v = (rb == 10) ? (r0 * 4 + r1 / 64) : (r0 * 16 + r1 / 16);
        else if (rb == 13) begin
            v = (r0 % 32) * 256 + r1;
            if (v >= 4096) v = v - 8192;
        end
        else if (rb == 10) v = (r0 * 32 + r1 / 8) % 1024;
        else v = (r0 * 128 + r1 / 2) % 4096;
        return 16'(v);
    endfunction

    function automatic bit exp_reject(int k, int ch);
        return (k == 5) || (ch >= NI[k]);
    endfunction

    // Driver: pushes the expected item, fires start, measures the latency
    task automatic issue(input int k, input int ch, input bit df,
                         input int r0, input int r1, input string tag);
        item_t it;
        int    cyc;
        int    nbits;
        it.err     = exp_reject(k, ch);
        nbits      = (NI[k] > 1 ? 8 : 0) + 8 * ((RB[k] + 7) / 8);
        it.bits    = nbits;
        it.cmd     = exp_cmd(NI[k], ch, df);
        it.cmd_tag = (NI[k] == 1) ? "R5" : ((NI[k] == 2) ? "R3" : "R4");
        it.tag     = tag;
        if (!it.err) begin
            last_res[k] = exp_res(NI[k], RB[k], r0, r1);
            frames_exp[k]++;
        end
        it.res    = last_res[k];
        it.frames = frames_exp[k];
        exp_q[k].push_back(it);
        @(negedge clk);
        chan[k]   = 3'(ch);
        diff[k]   = df;
        stream[k] = (NI[k] > 1) ? {8'hA5, 8'(r0), 8'(r1)} : {8'(r0), 8'(r1), 8'h3C};
        start[k]  = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            start[k] = 1'b0;
            cyc++;
        end while (!done[k] && cyc < 400);
        if (it.err) chk(cyc == 1, "R11", "reject latency", 32'(cyc), 32'd1);
        else chk(cyc == 2 * DIV * (nbits + 1) + 2, "R13", "start-to-done cycles",
                 32'(cyc), 32'(2 * DIV * (nbits + 1) + 2));
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops and compares on every done strobe
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < NV; k++) begin
                if (done[k]) begin
                    if (exp_q[k].size() == 0) begin
                        chk(1'b0, "R12", "unexpected done", 32'(k), 32'hFFFF_FFFF);
                    end else begin
                        item_t it;
                        it = exp_q[k].pop_front();
                        chk(err[k] == it.err, "R11", "error flag", 32'(err[k]), 32'(it.err));
                        chk(res[k] == it.res, it.tag, "result", 32'(res[k]), 32'(it.res));
                        chk(frames[k] == it.frames, "R12", "frame count",
                            32'(frames[k]), 32'(it.frames));
                        if (!it.err) begin
                            chk(cmd_seen[k] == it.cmd, it.cmd_tag, "command bits on MOSI (R2 order)",
                                32'(cmd_seen[k]), 32'(it.cmd));
                            chk(edges[k] == it.bits, "R6", "SCLK periods",
                                32'(edges[k]), 32'(it.bits));
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < NV; k++) begin
            start[k] = 1'b0; diff[k] = 1'b0; chan[k] = 3'd0; stream[k] = '0;
            last_res[k] = '0; frames_exp[k] = 0;
        end
        repeat (5) @(negedge clk);
        // R1: reset state on every variant
        for (int k = 0; k < NV; k++) begin
            chk(cs_n[k] == 1'b1 && sclk[k] == 1'b0 && mosi[k] == 1'b0, "R1", "bus idle",
                {29'd0, cs_n[k], sclk[k], mosi[k]}, 32'd4);
            chk(done[k] == 1'b0 && err[k] == 1'b0 && res[k] == 16'd0, "R1", "outputs clear",
                {14'd0, done[k], err[k], res[k]}, 32'd0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // 8-input 12-bit: R4, R7, R10
        issue(0, 0, 1'b0, 8'h0A, 8'hBC, "R7");
        issue(0, 7, 1'b0, 8'hFF, 8'hF0, "R7");
        issue(0, 3, 1'b1, 8'h05, 8'h5F, "R10");
        issue(0, 2, 1'b1, 8'h3C, 8'h81, "R10");
        // 4-input 12-bit: R4, R11
        issue(4, 2, 1'b1, 8'h12, 8'h34, "R10");
        issue(4, 4, 1'b0, 8'h77, 8'h77, "R11");
        issue(4, 1, 1'b0, 8'h80, 8'h0F, "R7");
        // 2-input 10-bit: R3, R7, R11
        issue(2, 1, 1'b0, 8'h9B, 8'hC0, "R7");
        issue(2, 0, 1'b1, 8'h01, 8'h7F, "R10");
        issue(2, 2, 1'b0, 8'h00, 8'h00, "R11");
        // 13-bit single-input: R9, R5, R11
        issue(1, 0, 1'b1, 8'h0F, 8'hFF, "R9");
        issue(1, 0, 1'b1, 8'h10, 8'h00, "R9");
        issue(1, 0, 1'b1, 8'hFF, 8'hFF, "R9");
        issue(1, 1, 1'b1, 8'h01, 8'h01, "R11");
        // 10- and 12-bit single-input with high garbage bits: R8
        issue(3, 0, 1'b1, 8'hE7, 8'hA8, "R8");
        issue(3, 0, 1'b1, 8'h1F, 8'hFF, "R8");
        issue(6, 0, 1'b1, 8'hF3, 8'h55, "R8");
        issue(6, 0, 1'b1, 8'h00, 8'h02, "R8");
        // unsupported variant: always rejected (R11)
        issue(5, 0, 1'b1, 8'h11, 8'h22, "R11");
        issue(5, 1, 1'b0, 8'h11, 8'h22, "R11");

        // R12: second start mid-frame is ignored
        fork
            issue(0, 6, 1'b0, 8'h44, 8'h90, "R12");
            begin
                repeat (30) @(negedge clk);
                chan[0]  = 3'd1;
                start[0] = 1'b1;
                @(negedge clk);
                start[0] = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        chk(frames[0] == frames_exp[0], "R12", "no extra frame", 32'(frames[0]), 32'(frames_exp[0]));

        for (int k = 0; k < NV; k++) begin
            chk(exp_q[k].size() == 0, "R13", "all expected completions seen",
                32'(exp_q[k].size()), 32'd0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule